// File: doc/BRIEF.md
# Exception Entry Controller

This block sits where instructions retire in a small in-order pipeline and decides, once per clock, whether control is diverted to a handler. It weighs three kinds of event: a reset request, a general exception flagged by one of the pipeline stages, and an interrupt request. When an event is taken, it flushes the pipeline, which cancels the faulting instruction so none of its results commit. It also saves the interrupted context into shadow registers, logs the event code, rewrites the mode bits of the status word and drives the handler address.

Each stage reports a fault flag, a user-break flag, a 12-bit cause code and the address of its instruction. Stage 0 holds the oldest instruction. The block has no data stream, so there is no valid/ready handshake: every pin is a plain control or status level, sampled on each rising clock edge. All outputs come from registers and change on the edge that samples the event.

Status word layout used throughout: bit 31 privileged mode, bit 30 register bank select, bit 29 event block, bit 8 FPU off, bits 3:0 interrupt mask.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A reset request outranks every other event. Its entry sets status bits 31, 30, 29 and 3:0 to 1, clears bit 8 and keeps the other bits. It drives 0xA0000000 as the handler address, writes code 0x000 to `exc_code_o`, reports offset 0 and leaves the saved registers unchanged.
- R2: On a general exception entry, `saved_sr_o` takes `cur_sr`, `saved_pc_o` takes the address of the faulting stage and `saved_r15_o` takes `cur_r15`. The stage's code goes to `exc_code_o`, and `irq_code_o` is unchanged.
- R3: On a general exception or interrupt entry, `new_sr_o` equals `cur_sr` with bits 31, 30 and 29 set and all other bits kept.
- R4: If `ubrk_en` is 1 and the accepted stage has its user-break flag set, the handler address is `dbg_base` and the offset is 0. Otherwise a general exception goes to `vec_base + 0x100`, with offset 0x100.
- R5: When several stages flag faults, the stage with the lowest index (the oldest instruction) is accepted.
- R6: An interrupt is taken only when no stage flags a fault. Its entry saves `cur_sr`, `cur_pc` and `cur_r15`, and writes `irq_code` to `irq_code_o` while `exc_code_o` is unchanged. The handler is `vec_base + 0x600`, with offset 0x600.
- R7: An interrupt request is ignored while `cur_sr` bit 29 is 1. No flush occurs and every output keeps its value.
- R8: A general exception taken while `cur_sr` bit 29 is 1 goes to 0xA0000000 with the R1 status rewrite and offset 0. It records its code in `exc_code_o` and leaves the saved registers unchanged.
- R9: `flush_o` rises in the cycle after the edge that sampled the event and stays high for exactly one cycle. Requests present while `flush_o` is high are ignored.
- R10: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req | input | 1 | Reset event request |
| stg_exc | input | NSTG | Per-stage fault flag, bit 0 oldest |
| stg_ubrk | input | NSTG | Per-stage user-break flag |
| stg_code | input | NSTG*12 | Per-stage cause codes, stage i at [12i +: 12] |
| stg_pc | input | NSTG*32 | Per-stage instruction addresses, stage i at [32i +: 32] |
| irq_req | input | 1 | Interrupt request |
| irq_code | input | 12 | Interrupt cause code |
| cur_sr | input | 32 | Current status word |
| cur_pc | input | 32 | Address of the next instruction, saved on interrupts |
| cur_r15 | input | 32 | Current stack pointer register |
| vec_base | input | 32 | Handler vector base |
| dbg_base | input | 32 | Debug handler address |
| ubrk_en | input | 1 | User-break debug redirect enable |
| flush_o | output | 1 | One-cycle cancel and redirect strobe |
| redirect_pc_o | output | 32 | Handler address, valid with flush_o |
| new_sr_o | output | 32 | Rewritten status word, valid with flush_o |
| saved_sr_o | output | 32 | Saved status word |
| saved_pc_o | output | 32 | Saved program counter |
| saved_r15_o | output | 32 | Saved stack pointer |
| exc_code_o | output | 12 | Last general exception or reset code |
| irq_code_o | output | 12 | Last interrupt code |
| vec_off_o | output | 32 | Vector offset used for the last entry |

## Verification
A fault flag and an interrupt request can arrive in the same cycle, so a general exception and an interrupt compete for acceptance. Reset requests, the event block bit and the user-break bits can also overlap them. The bench sweeps every combination of the fault mask, the user-break mask, the interrupt request, the block bit and the debug enable, with reset requests on top. It computes the winning event and every register value arithmetically, and holds each stimulus for a second cycle to confirm that the flush cycle discards it.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN    = 32;
  localparam int CODE_W  = 12;
  localparam int SR_PRIV = 31;
  localparam int SR_BANK = 30;
  localparam int SR_BLK  = 29;
  localparam int SR_FPD  = 8;
  localparam int SR_MSKW = 4;

  localparam logic [XLEN-1:0]   RESET_VEC  = 32'hA000_0000;
  localparam logic [XLEN-1:0]   GEN_OFF    = 32'h0000_0100;
  localparam logic [XLEN-1:0]   IRQ_OFF    = 32'h0000_0600;
  localparam logic [CODE_W-1:0] RESET_CODE = '0;

  typedef enum logic [1:0] {EV_NONE, EV_RESET, EV_GEN, EV_IRQ} ev_kind_e;

  function automatic logic [XLEN-1:0] sr_on_entry(input logic [XLEN-1:0] s);
    logic [XLEN-1:0] r;
    r = s;
    r[SR_PRIV] = 1'b1;
    r[SR_BANK] = 1'b1;
    r[SR_BLK]  = 1'b1;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] sr_on_reset(input logic [XLEN-1:0] s);
    logic [XLEN-1:0] r;
    r = sr_on_entry(s);
    r[SR_MSKW-1:0] = '1;
    r[SR_FPD] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/exc_order_pick.sv
module exc_order_pick #(
  parameter int NSTG  = 3,
  localparam int IDX_W = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input  logic [NSTG-1:0]  req,
  output logic [NSTG-1:0]  gnt,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [NSTG:0] older;

  assign older[0] = 1'b0;
  for (genvar g = 0; g < NSTG; g++) begin : g_chain
    assign gnt[g]     = req[g] & ~older[g];
    assign older[g+1] = older[g] | req[g];
  end
  assign any = older[NSTG];

  always_comb begin
    idx = '0;
    for (int i = NSTG - 1; i >= 0; i--) begin
      if (gnt[i]) idx = IDX_W'(i);
    end
  end

  // R5: at most one stage is granted, and one is granted whenever any asks
  always_comb begin
    a_r5_one_grant: assert ($onehot0(gnt) && ((gnt != '0) == (req != '0)));
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_pkg::*;
(
  input  ev_kind_e        kind,
  input  logic            blocked,
  input  logic            dbg_hit,
  input  logic [XLEN-1:0] vec_base,
  input  logic [XLEN-1:0] dbg_base,
  output logic [XLEN-1:0] handler_pc,
  output logic [XLEN-1:0] offset
);
  always_comb begin
    handler_pc = '0;
    offset     = '0;
    unique case (kind)
      EV_RESET: handler_pc = RESET_VEC;
      EV_GEN: begin
        if (blocked) begin
          handler_pc = RESET_VEC;
        end else if (dbg_hit) begin
          handler_pc = dbg_base;
        end else begin
          offset     = GEN_OFF;
          handler_pc = vec_base + GEN_OFF;
        end
      end
      EV_IRQ: begin
        offset     = IRQ_OFF;
        handler_pc = vec_base + IRQ_OFF;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int NSTG = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rst_req,
  input  logic [NSTG-1:0]          stg_exc,
  input  logic [NSTG-1:0]          stg_ubrk,
  input  logic [NSTG*CODE_W-1:0]   stg_code,
  input  logic [NSTG*XLEN-1:0]     stg_pc,
  input  logic                     irq_req,
  input  logic [CODE_W-1:0]        irq_code,
  input  logic [XLEN-1:0]          cur_sr,
  input  logic [XLEN-1:0]          cur_pc,
  input  logic [XLEN-1:0]          cur_r15,
  input  logic [XLEN-1:0]          vec_base,
  input  logic [XLEN-1:0]          dbg_base,
  input  logic                     ubrk_en,
  output logic                     flush_o,
  output logic [XLEN-1:0]          redirect_pc_o,
  output logic [XLEN-1:0]          new_sr_o,
  output logic [XLEN-1:0]          saved_sr_o,
  output logic [XLEN-1:0]          saved_pc_o,
  output logic [XLEN-1:0]          saved_r15_o,
  output logic [CODE_W-1:0]        exc_code_o,
  output logic [CODE_W-1:0]        irq_code_o,
  output logic [XLEN-1:0]          vec_off_o
);
  localparam int IDX_W = (NSTG > 1) ? $clog2(NSTG) : 1;

  logic [NSTG-1:0]   gnt;
  logic              gen_any;
  logic [IDX_W-1:0]  idx;
  logic [CODE_W-1:0] sel_code;
  logic [XLEN-1:0]   sel_pc;
  logic              sel_ubrk;
  logic              blocked;
  ev_kind_e          kind;
  logic [XLEN-1:0]   hpc;
  logic [XLEN-1:0]   hoff;

  exc_order_pick #(.NSTG(NSTG)) u_pick (
    .req (stg_exc),
    .gnt (gnt),
    .any (gen_any),
    .idx (idx)
  );

  assign sel_code = stg_code[int'(idx)*CODE_W +: CODE_W];
  assign sel_pc   = stg_pc[int'(idx)*XLEN +: XLEN];
  assign sel_ubrk = |(gnt & stg_ubrk);
  assign blocked  = cur_sr[SR_BLK];

  // Requests seen while the flush strobe is high belong to cancelled work.
  always_comb begin
    if (flush_o)                  kind = EV_NONE;
    else if (rst_req)             kind = EV_RESET;
    else if (gen_any)             kind = EV_GEN;
    else if (irq_req && !blocked) kind = EV_IRQ;
    else                          kind = EV_NONE;
  end

  exc_vector_gen u_vec (
    .kind       (kind),
    .blocked    (blocked),
    .dbg_hit    (ubrk_en & sel_ubrk),
    .vec_base   (vec_base),
    .dbg_base   (dbg_base),
    .handler_pc (hpc),
    .offset     (hoff)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_o       <= 1'b0;
      redirect_pc_o <= '0;
      new_sr_o      <= '0;
      saved_sr_o    <= '0;
      saved_pc_o    <= '0;
      saved_r15_o   <= '0;
      exc_code_o    <= '0;
      irq_code_o    <= '0;
      vec_off_o     <= '0;
    end else begin
      flush_o <= (kind != EV_NONE);
      if (kind != EV_NONE) begin
        redirect_pc_o <= hpc;
        vec_off_o     <= hoff;
      end
      unique case (kind)
        EV_RESET: begin
          new_sr_o   <= sr_on_reset(cur_sr);
          exc_code_o <= RESET_CODE;
        end
        EV_GEN: begin
          exc_code_o <= sel_code;
          if (blocked) begin
            new_sr_o <= sr_on_reset(cur_sr);
          end else begin
            new_sr_o    <= sr_on_entry(cur_sr);
            saved_sr_o  <= cur_sr;
            saved_pc_o  <= sel_pc;
            saved_r15_o <= cur_r15;
          end
        end
        EV_IRQ: begin
          irq_code_o  <= irq_code;
          new_sr_o    <= sr_on_entry(cur_sr);
          saved_sr_o  <= cur_sr;
          saved_pc_o  <= cur_pc;
          saved_r15_o <= cur_r15;
        end
        default: ;
      endcase
    end
  end

  a_r9_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o);

  a_r1_reset_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !flush_o) |=> (flush_o && redirect_pc_o == RESET_VEC));

  a_r3_mode_bits: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (new_sr_o[SR_PRIV] && new_sr_o[SR_BANK] && new_sr_o[SR_BLK]));

  a_r7_irq_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && cur_sr[SR_BLK] && !rst_req && stg_exc == '0) |=> !flush_o);

  a_r2_saved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_o |-> ($stable(saved_sr_o) && $stable(saved_pc_o) && $stable(saved_r15_o)));
endmodule

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
  localparam int NSTG = 3;
  localparam logic [31:0] RV = 32'hA000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_req = 1'b0;
  logic [NSTG-1:0] stg_exc = '0, stg_ubrk = '0;
  logic [NSTG*12-1:0] stg_code = '0;
  logic [NSTG*32-1:0] stg_pc = '0;
  logic irq_req = 1'b0;
  logic [11:0] irq_code = '0;
  logic [31:0] cur_sr = '0, cur_pc = '0, cur_r15 = '0, vec_base = '0, dbg_base = '0;
  logic ubrk_en = 1'b0;
  logic flush_o;
  logic [31:0] redirect_pc_o, new_sr_o, saved_sr_o, saved_pc_o, saved_r15_o, vec_off_o;
  logic [11:0] exc_code_o, irq_code_o;

  int checks = 0, failures = 0;
  logic [31:0] e_rpc = '0, e_nsr = '0, e_ssr = '0, e_spc = '0, e_sr15 = '0, e_off = '0;
  logic [11:0] e_exc = '0, e_irq = '0;

  always #4 clk = ~clk;

  exc_entry_ctrl #(.NSTG(NSTG)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " redirect"}, redirect_pc_o, e_rpc);
    chk({tag, " new_sr"}, new_sr_o, e_nsr);
    chk({tag, " saved_sr"}, saved_sr_o, e_ssr);
    chk({tag, " saved_pc"}, saved_pc_o, e_spc);
    chk({tag, " saved_r15"}, saved_r15_o, e_sr15);
    chk({tag, " exc_code"}, {20'd0, exc_code_o}, {20'd0, e_exc});
    chk({tag, " irq_code"}, {20'd0, irq_code_o}, {20'd0, e_irq});
    chk({tag, " offset"}, vec_off_o, e_off);
  endtask

  function automatic logic [31:0] sr_ent(input logic [31:0] s);
    return s | 32'hE000_0000;
  endfunction
  function automatic logic [31:0] sr_rst(input logic [31:0] s);
    return (s | 32'hE000_000F) & ~32'h0000_0100;
  endfunction

  task automatic run_case(input int n, input bit rr, input logic [2:0] v, input logic [2:0] ub,
                          input bit irq, input bit blk, input bit uen);
    int first;
    bit ev;
    @(negedge clk);
    rst_req = rr; stg_exc = v; stg_ubrk = ub; irq_req = irq; ubrk_en = uen;
    irq_code = 12'(12'h500 + n);
    for (int i = 0; i < NSTG; i++) begin
      stg_code[i*12 +: 12] = 12'(n * 3 + i + 1);
      stg_pc[i*32 +: 32]   = 32'h1000_0000 + 32'(n * 16 + i * 4);
    end
    cur_sr = ((32'h0123_4567 ^ 32'(n << 8)) & ~32'hE000_0000) | (blk ? 32'h2000_0000 : 32'h0);
    cur_pc = 32'h2000_0000 + 32'(n * 4);
    cur_r15 = 32'h7FFF_0000 - 32'(n);
    vec_base = 32'h8000_0000 + 32'(n << 12);
    dbg_base = 32'hC000_0000 + 32'(n);
    first = -1;
    for (int i = NSTG - 1; i >= 0; i--) if (v[i]) first = i;
    ev = 1'b1;
    if (rr) begin
      e_rpc = RV; e_nsr = sr_rst(cur_sr); e_exc = 12'h000; e_off = 0;
    end else if (first >= 0) begin
      e_exc = stg_code[first*12 +: 12];
      if (blk) begin
        e_rpc = RV; e_nsr = sr_rst(cur_sr); e_off = 0;
      end else begin
        e_nsr = sr_ent(cur_sr); e_ssr = cur_sr; e_spc = stg_pc[first*32 +: 32]; e_sr15 = cur_r15;
        if (uen && ub[first]) begin e_rpc = dbg_base; e_off = 0; end
        else begin e_rpc = vec_base + 32'h100; e_off = 32'h100; end
      end
    end else if (irq && !blk) begin
      e_irq = irq_code; e_nsr = sr_ent(cur_sr); e_ssr = cur_sr; e_spc = cur_pc; e_sr15 = cur_r15;
      e_rpc = vec_base + 32'h600; e_off = 32'h600;
    end else ev = 1'b0;
    @(negedge clk);
    chk("R9 flush on event", {31'd0, flush_o}, {31'd0, ev});
    if (rr) chk_all("R1 reset entry");
    else if (first >= 0 && blk) chk_all("R8 blocked exception");
    else if (first >= 0) chk_all("R2 R3 R4 R5 general entry");
    else if (irq && !blk) chk_all("R6 interrupt entry");
    else chk_all("R7 no event hold");
    @(negedge clk);
    if (ev) begin
      chk("R9 single cycle flush", {31'd0, flush_o}, 32'd0);
      chk_all("R9 held request ignored");
    end
    rst_req = 0; stg_exc = '0; irq_req = 0;
    @(negedge clk);
    chk("R9 idle", {31'd0, flush_o}, 32'd0);
  endtask

  initial begin
    #(200000 * 8);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    #20;
    chk("R10 reset flush", {31'd0, flush_o}, 32'd0);
    chk_all("R10 reset values");
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    for (int rr = 0; rr < 2; rr++)
      for (int v = 0; v < 8; v++)
        for (int ub = 0; ub < 8; ub++)
          for (int irq = 0; irq < 2; irq++)
            for (int blk = 0; blk < 2; blk++)
              for (int uen = 0; uen < 2; uen++) begin
                if (rr == 0 || (ub == 0 && uen == 0)) begin
                  run_case(n, rr[0], v[2:0], ub[2:0], irq[0], blk[0], uen[0]);
                  n++;
                end
              end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule